// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one page table entry from memory. When a request is accepted, the virtual page number (the address bits above the page offset) is added to a table base address. The sum is the word address of the entry. The walker issues a single read for that word and waits for the data. It then decodes the entry's present bit, permission bits and kernel-only bit against the request's access type and privilege level.

The walker returns a response for one cycle. If the entry is present and the access is allowed, the response carries the physical address. This address is the entry's physical page number followed by the untouched page offset. Otherwise it carries a fault code and a zero address. Only one walk is in flight at any time, and new requests are held off until the current response has been given.

With default parameters, a virtual address is 14 bits, a physical address is 12 bits and a page is 64 bytes. This gives an 8-bit virtual page number and a 6-bit physical page number. Entries are 16-bit memory words, and the entry address is 12 bits.

Top module: `pt_walker`

## Requirements
- R1: After reset, reqReady is 1, and memReqValid and rspValid are both 0.
- R2: In the cycle after a request is accepted, memReqValid rises and memReqAddr equals ptBase plus reqVaddr[13:6], modulo 4096. Both are held until memReqReady is seen high.
- R3: A present and permitted entry gives rspFault = 00 and rspPaddr = {entry[5:0], reqVaddr[5:0]}.
- R4: An entry whose present bit (bit 6) is 0 gives rspFault = 01 and rspPaddr = 0. This holds whatever its permission bits are, so the page fault outranks a protection fault.
- R5: A read (reqWrite = 0) to a present entry whose read-permission bit (bit 7) is 0 gives rspFault = 10 and rspPaddr = 0.
- R6: A write (reqWrite = 1) is decided only by the write-permission bit (bit 8). If bit 8 is 0, the result is rspFault = 10. If bit 8 is 1, the write is allowed even when bit 7 is 0.
- R7: A user-mode request (reqUser = 1) to an entry whose kernel-only bit (bit 9) is 1 gives rspFault = 10. A kernel-mode request (reqUser = 0) ignores bit 9.
- R8: reqReady is 0 from the cycle after acceptance until the cycle after the response. Requests offered during that time are ignored and do not change the result in progress.
- R9: rspValid is high for exactly one cycle, in the cycle after the one where memRspValid is sampled high.
- R10: Entry bits 15:10 have no effect on the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Translation request offered |
| reqReady | output | 1 | Walker idle, will accept a request |
| reqVaddr | input | 14 | Virtual address to translate |
| reqWrite | input | 1 | Access type: 1 write, 0 read |
| reqUser | input | 1 | Privilege: 1 user, 0 kernel |
| ptBase | input | 12 | Table base word address, captured at acceptance |
| memReqValid | output | 1 | Entry read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 12 | Word address of the entry |
| memRspValid | input | 1 | Entry data returned |
| memRspData | input | 16 | Entry word |
| rspValid | output | 1 | Response pulse |
| rspPaddr | output | 12 | Physical address, zero on a fault |
| rspFault | output | 2 | 00 ok, 01 page fault, 10 protection fault |

## Verification
A stuck or skipped control state shows up at the ports within one cycle. It appears as memReqValid missing after acceptance, as reqReady rising in the middle of a walk, or as a response that is absent or lasts more than one cycle. A captured field that is wrong or gets overwritten shows up in the entry address during the fetch. It also shows up in the response, where the offset, the page number or the fault code differs. The bench offers conflicting requests during walks and stalls both memory handshakes. This exposes any capture that is not protected by the busy state.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_PAGE = 2'b01,
    FLT_PROT = 2'b10
  } ptwFault_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_DONE
  } ptwState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;
    logic capEntry;
  } ptwStrobe_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       memReqValid,
  input  logic       memReqReady,
  input  logic       memRspValid,
  output logic       rspValid,
  output ptwStrobe_t strobe
);
  ptwState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (reqValid)    stateNext = ST_FETCH;
      ST_FETCH: if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT:  if (memRspValid) stateNext = ST_DONE;
      ST_DONE:                   stateNext = ST_IDLE;
      default:                   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady        = (state == ST_IDLE);
  assign memReqValid     = (state == ST_FETCH);
  assign rspValid        = (state == ST_DONE);
  assign strobe.capReq   = (state == ST_IDLE) && reqValid;
  assign strobe.capEntry = (state == ST_WAIT) && memRspValid;

  AST_FETCH_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> memReqValid); // R2
  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid); // R2
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || rspValid) |-> !reqReady); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R9
  AST_RSP_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(memRspValid)); // R9
  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({reqReady, memReqValid, rspValid})); // R8
endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
#(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int MA_W  = 12,
  parameter int PTE_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ptwStrobe_t       strobe,
  input  logic             rspValid,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqWrite,
  input  logic             reqUser,
  input  logic [MA_W-1:0]  ptBase,
  input  logic [PTE_W-1:0] memRspData,
  input  logic             memReqValid,
  input  logic             memReqReady,
  output logic [MA_W-1:0]  memReqAddr,
  output logic [PA_W-1:0]  rspPaddr,
  output logic [1:0]       rspFault
);
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int PPN_W   = PA_W - OFF_W;
  localparam int BIT_VAL = PPN_W;
  localparam int BIT_RD  = PPN_W + 1;
  localparam int BIT_WR  = PPN_W + 2;
  localparam int BIT_KRN = PPN_W + 3;

  logic [VA_W-1:0]  vaddrQ;
  logic             writeQ;
  logic             userQ;
  logic [MA_W-1:0]  baseQ;
  logic [PTE_W-1:0] entryQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaddrQ <= '0;
      writeQ <= 1'b0;
      userQ  <= 1'b0;
      baseQ  <= '0;
    end else if (strobe.capReq) begin
      vaddrQ <= reqVaddr;
      writeQ <= reqWrite;
      userQ  <= reqUser;
      baseQ  <= ptBase;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                entryQ <= '0;
    else if (strobe.capEntry) entryQ <= memRspData;
  end

  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] pageOff;
  assign vpn     = vaddrQ[VA_W-1:OFF_W];
  assign pageOff = vaddrQ[OFF_W-1:0];
  assign memReqAddr = baseQ + MA_W'(vpn);

  logic entryValid, rdOk, wrOk, krnOnly, rightsOk;
  assign entryValid = entryQ[BIT_VAL];
  assign rdOk       = entryQ[BIT_RD];
  assign wrOk       = entryQ[BIT_WR];
  assign krnOnly    = entryQ[BIT_KRN];
  assign rightsOk   = (writeQ ? wrOk : rdOk) && !(userQ && krnOnly);

  ptwFault_t fault;
  always_comb begin
    if (!entryValid)    fault = FLT_PAGE;
    else if (!rightsOk) fault = FLT_PROT;
    else                fault = FLT_NONE;
  end

  assign rspFault = fault;
  assign rspPaddr = (fault == FLT_NONE) ? {entryQ[PPN_W-1:0], pageOff} : '0;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr)); // R2
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 2'b00) |-> (rspPaddr == '0)); // R4
  AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspFault != 2'b11)); // R3
  AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || rspValid) |=> $stable(vaddrQ)); // R8
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int MA_W  = 12,
  parameter int PTE_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqWrite,
  input  logic             reqUser,
  input  logic [MA_W-1:0]  ptBase,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic [MA_W-1:0]  memReqAddr,
  input  logic             memRspValid,
  input  logic [PTE_W-1:0] memRspData,
  output logic             rspValid,
  output logic [PA_W-1:0]  rspPaddr,
  output logic [1:0]       rspFault
);
  ptwStrobe_t strobe;

  ptw_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .rspValid    (rspValid),
    .strobe      (strobe)
  );

  ptw_dpath #(
    .VA_W (VA_W), .PA_W (PA_W), .OFF_W (OFF_W), .MA_W (MA_W), .PTE_W (PTE_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rspValid    (rspValid),
    .reqVaddr    (reqVaddr),
    .reqWrite    (reqWrite),
    .reqUser     (reqUser),
    .ptBase      (ptBase),
    .memRspData  (memRspData),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memReqAddr  (memReqAddr),
    .rspPaddr    (rspPaddr),
    .rspFault    (rspFault)
  );
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0;
  logic        reqReady;
  logic [13:0] reqVaddr = '0;
  logic        reqWrite = 0;
  logic        reqUser = 0;
  logic [11:0] ptBase = '0;
  logic        memReqValid;
  logic        memReqReady = 0;
  logic [11:0] memReqAddr;
  logic        memRspValid = 0;
  logic [15:0] memRspData = '0;
  logic        rspValid;
  logic [11:0] rspPaddr;
  logic [1:0]  rspFault;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .reqUser(reqUser), .ptBase(ptBase),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspPaddr(rspPaddr), .rspFault(rspFault)
  );

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  // independent model of the response: {fault, paddr}
  function automatic logic [13:0] model(input logic [13:0] va, input logic wr,
                                        input logic usr, input logic [15:0] pte);
    logic [1:0] f;
    if (!pte[6]) f = 2'b01;
    else if ((usr && pte[9]) || (wr && !pte[8]) || (!wr && !pte[7])) f = 2'b10;
    else f = 2'b00;
    return {f, (f == 2'b00) ? {pte[5:0], va[5:0]} : 12'h000};
  endfunction

  task automatic doWalk(input logic [13:0] va, input logic wr, input logic usr,
                        input logic [11:0] base, input logic [15:0] pte,
                        input int readyDly, input int rspDly, input bit disturb,
                        input string tag);
    logic [13:0] exp;
    logic [11:0] expAddr;
    exp = model(va, wr, usr, pte);
    expAddr = base + {4'h0, va[13:6]};
    @(negedge clk);
    check(reqReady == 1'b1, {tag, " idle ready"}, reqReady, 1);
    reqValid = 1; reqVaddr = va; reqWrite = wr; reqUser = usr; ptBase = base;
    @(negedge clk);
    if (disturb) begin
      reqVaddr = ~va; reqWrite = ~wr; reqUser = ~usr; ptBase = ~base;
    end else reqValid = 0;
    check(memReqValid == 1'b1, "R2 fetch starts", memReqValid, 1);
    check(memReqAddr == expAddr, "R2 entry address", memReqAddr, expAddr);
    for (int i = 0; i < readyDly; i++) begin
      @(negedge clk);
      check(memReqValid && memReqAddr == expAddr, "R2 fetch held", memReqAddr, expAddr);
      check(reqReady == 1'b0, "R8 busy during fetch", reqReady, 0);
    end
    memReqReady = 1;
    @(negedge clk);
    memReqReady = 0;
    check(memReqValid == 1'b0, "R2 fetch drops", memReqValid, 0);
    for (int i = 0; i < rspDly; i++) begin
      @(negedge clk);
      check(reqReady == 1'b0 && rspValid == 1'b0, "R8 busy during wait", reqReady, 0);
    end
    memRspValid = 1; memRspData = pte;
    if (disturb) check(reqReady == 1'b0, "R8 busy before data", reqReady, 0);
    @(negedge clk);
    memRspValid = 0; memRspData = 16'hFFFF;
    reqValid = 0;
    check(rspValid == 1'b1, "R9 response pulse", rspValid, 1);
    check(rspFault == exp[13:12], {tag, " fault code"}, rspFault, exp[13:12]);
    check(rspPaddr == exp[11:0], {tag, " physical address"}, rspPaddr, exp[11:0]);
    check(reqReady == 1'b0, "R8 busy during response", reqReady, 0);
    @(negedge clk);
    check(rspValid == 1'b0, "R9 pulse one cycle", rspValid, 0);
    check(reqReady == 1'b1, "R8 ready after response", reqReady, 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(reqReady == 1'b1, "R1 reqReady", reqReady, 1);
    check(memReqValid == 1'b0, "R1 memReqValid", memReqValid, 0);
    check(rspValid == 1'b0, "R1 rspValid", rspValid, 0);
  endtask

  task automatic testTranslate();
    doWalk(14'h03D4, 0, 0, 12'h000, 16'h00CD, 0, 0, 0, "R3");
    doWalk(14'h3FFF, 0, 1, 12'h123, 16'h01FF, 2, 3, 0, "R3");
    doWalk(14'h0040, 1, 1, 12'h800, 16'h01C0, 1, 0, 0, "R3");
  endtask

  task automatic testAddrWrap();
    doWalk(14'h0805, 0, 0, 12'hFF0, 16'h0095, 0, 1, 0, "R2");
  endtask

  task automatic testPageFault();
    doWalk(14'h1234, 0, 0, 12'h010, 16'h003F, 0, 0, 0, "R4");
    doWalk(14'h1234, 1, 1, 12'h010, 16'h023F, 1, 1, 0, "R4");
  endtask

  task automatic testReadDenied();
    doWalk(14'h0ABC, 0, 0, 12'h040, 16'h0148, 0, 0, 0, "R5");
  endtask

  task automatic testWriteRules();
    doWalk(14'h0F0F, 1, 0, 12'h000, 16'h0152, 0, 0, 0, "R6");
    doWalk(14'h0F0F, 1, 0, 12'h000, 16'h00D2, 0, 0, 0, "R6");
  endtask

  task automatic testKernel();
    doWalk(14'h2222, 0, 1, 12'h100, 16'h03CA, 0, 0, 0, "R7");
    doWalk(14'h2222, 1, 0, 12'h100, 16'h03CA, 0, 0, 0, "R7");
  endtask

  task automatic testBusyIgnore();
    doWalk(14'h1555, 0, 0, 12'h0A0, 16'h00E7, 3, 2, 1, "R8");
    doWalk(14'h2AAA, 1, 1, 12'h3F0, 16'h0021, 2, 4, 1, "R8");
  endtask

  task automatic testUpperIgnored();
    doWalk(14'h0777, 0, 1, 12'h200, 16'hFCD9, 0, 0, 0, "R10");
    doWalk(14'h0777, 1, 0, 12'h200, 16'hFC59, 0, 0, 0, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testTranslate();
    testAddrWrap();
    testPageFault();
    testReadDenied();
    testWriteRules();
    testKernel();
    testBusyIgnore();
    testUpperIgnored();
    finishRun();
  end
endmodule